// File: doc/BRIEF.md
# Field-Configurable Programmable Logic Array with Output Polarity

This block evaluates a user-defined set of sum-of-products functions. It takes `N_IN` inputs and has `N_TERM` product terms and `N_OUT` outputs. Each product term is an AND of any chosen literals, where a literal is an input taken true or complemented. Each output is an OR of any chosen product terms, so one term can serve several outputs at once. The OR result then goes through an XOR with a per-output polarity bit, which lets each output be inverted independently. The input-to-output path is purely combinational.

The configuration is held in volatile flip-flops and is all zeros after reset. It is loaded serially into a shadow shift register while `cfg_shift` is high, one bit per clock. A one-cycle `cfg_load` pulse then copies the whole shadow register into the active configuration at once. Outputs therefore never see a half-written function. The asynchronous active-low reset is released through a two-stage synchroniser inside the block.

Top module: `pla_core`

## Requirements
- R1: While reset is asserted, and afterwards until the first `cfg_load`, the active configuration is all zeros and `out_vec` is 0 for every input value.
- R2: While `cfg_shift` is high, each clock shifts `cfg_din` into the shadow register. Bit s of the stream (s = 0 first) lands at configuration index s after all `CFG_BITS` bits are in. The layout is as follows. The AND literal of term t and input i sits at index t*2*N_IN + 2*i for the true form and at that index + 1 for the complement. The OR connection of term t to output o sits at AND_BITS + o*N_TERM + t, where AND_BITS = 2*N_IN*N_TERM. The polarity bit of output o sits at AND_BITS + N_TERM*N_OUT + o.
- R3: A `cfg_load` sampled high at a clock edge copies the shadow register, as it stood before that edge, into the active configuration. Outputs keep the old function before that edge and show the new function right after it.
- R4: Without `cfg_load`, shifting new bits into the shadow register has no effect on `out_vec`.
- R5: A term is 1 only when every enabled literal is 1. A literal that is not enabled has no effect on its term.
- R6: A term with no literal enabled evaluates to 0.
- R7: A term that enables both the true and the complement form of the same input always evaluates to 0.
- R8: Each output is the OR of the terms connected to it. A single term may drive several outputs.
- R9: An output with no term connected gives 0 before the polarity stage.
- R10: A polarity bit of 1 inverts its output, and a polarity bit of 0 passes the OR result unchanged.
- R11: `out_vec` follows a change of `in_vec` within the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Enables one serial shift per clock |
| cfg_din | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copies shadow configuration into the active one |
| in_vec | input | N_IN | Function inputs |
| out_vec | output | N_OUT | Function outputs |

## Verification
The assertions assume two things about the inputs. First, `in_vec` changes only between clock edges. Second, no `cfg_load` arrives while the internal synchronised reset is still low. This keeps the zero-until-load and copy-on-load properties meaningful. The stimulus keeps within both assumptions: it drives every input on the falling edge and waits several cycles after reset release before it shifts or loads anything. The no-term-connected check relates the OR plane's configuration directly to each output's value. This holds whatever pattern `in_vec` carries.

// File: rtl/pla_pkg.sv
package pla_pkg;

  function automatic int unsigned and_bits(input int unsigned n_in, input int unsigned n_term);
    return 2 * n_in * n_term;
  endfunction

  function automatic int unsigned or_bits(input int unsigned n_term, input int unsigned n_out);
    return n_term * n_out;
  endfunction

  function automatic int unsigned cfg_bits(input int unsigned n_in, input int unsigned n_term,
                                           input int unsigned n_out);
    return and_bits(n_in, n_term) + or_bits(n_term, n_out) + n_out;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
// Serial shadow register plus active configuration copy.
module pla_cfg_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         load_en,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active
);

  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] active_q, active_d;

  // first bit shifted ends up at index 0 once W bits are in
  always_comb begin
    shadow_d = {shift_bit, shadow_q[W-1:1]};
    active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shift_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (load_en) begin
      active_q <= active_d;
    end
  end

  assign shadow = shadow_q;
  assign active = active_q;

endmodule

// File: rtl/pla_and_plane.sv
// Programmable AND plane: one product term per row of the mask.
module pla_and_plane #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 6
) (
  input  logic [N_IN-1:0]             in_vec,
  input  logic [2*N_IN*N_TERM-1:0]    mask,
  output logic [N_TERM-1:0]           terms
);

  localparam int unsigned ROW = 2 * N_IN;

  logic [ROW-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_vec[i];
    assign lits[2*i+1] = ~in_vec[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW-1:0] row;
    assign row = mask[t*ROW +: ROW];
    // empty row gives 0; disabled literals are forced to 1 before the AND
    assign terms[t] = (|row) & (&(lits | ~row));
  end

endmodule

// File: rtl/pla_or_plane.sv
// Programmable OR plane followed by per-output polarity XOR.
module pla_or_plane #(
  parameter int unsigned N_TERM = 6,
  parameter int unsigned N_OUT  = 3
) (
  input  logic [N_TERM-1:0]        terms,
  input  logic [N_TERM*N_OUT-1:0]  conn,
  input  logic [N_OUT-1:0]         invert,
  output logic [N_OUT-1:0]         out_vec
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic sum;
    assign sum        = |(terms & conn[o*N_TERM +: N_TERM]);
    assign out_vec[o] = sum ^ invert[o];
  end

endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 6,
  parameter int unsigned N_OUT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  localparam int unsigned A_BITS = and_bits(N_IN, N_TERM);
  localparam int unsigned O_BITS = or_bits(N_TERM, N_OUT);
  localparam int unsigned C_BITS = cfg_bits(N_IN, N_TERM, N_OUT);
  localparam int unsigned O_OFF  = A_BITS;
  localparam int unsigned P_OFF  = A_BITS + O_BITS;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [C_BITS-1:0] cfg_shadow;
  logic [C_BITS-1:0] cfg_active;
  logic [N_TERM-1:0] terms;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  pla_cfg_chain #(.W(C_BITS)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (cfg_shift),
    .shift_bit (cfg_din),
    .load_en   (cfg_load),
    .shadow    (cfg_shadow),
    .active    (cfg_active)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) i_and (
    .in_vec (in_vec),
    .mask   (cfg_active[A_BITS-1:0]),
    .terms  (terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) i_or (
    .terms   (terms),
    .conn    (cfg_active[O_OFF +: O_BITS]),
    .invert  (cfg_active[P_OFF +: N_OUT]),
    .out_vec (out_vec)
  );

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 6,
  parameter int unsigned N_OUT  = 3
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     cfg_shift,
  input logic                                     cfg_din,
  input logic                                     cfg_load,
  input logic [N_IN-1:0]                          in_vec,
  input logic [N_OUT-1:0]                         out_vec,
  input logic [cfg_bits(N_IN, N_TERM, N_OUT)-1:0] cfg_shadow,
  input logic [cfg_bits(N_IN, N_TERM, N_OUT)-1:0] cfg_active
);

  localparam int unsigned C_BITS = cfg_bits(N_IN, N_TERM, N_OUT);
  localparam int unsigned O_OFF  = and_bits(N_IN, N_TERM);
  localparam int unsigned P_OFF  = O_OFF + or_bits(N_TERM, N_OUT);

  logic seen_load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_load_q <= 1'b0;
    end else if (cfg_load) begin
      seen_load_q <= 1'b1;
    end
  end

  p_zero_before_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load_q |-> (out_vec == '0));

  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> (cfg_shadow[C_BITS-1] == $past(cfg_din)));

  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (cfg_active == $past(cfg_shadow)));

  p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_active));

  p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_load) && $stable(in_vec)) |-> $stable(out_vec));

  for (genvar o = 0; o < N_OUT; o++) begin : g_empty
    p_empty_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_active[O_OFF + o*N_TERM +: N_TERM] == '0) |-> (out_vec[o] == cfg_active[P_OFF + o]));
  end

endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) i_pla_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_shift  (cfg_shift),
  .cfg_din    (cfg_din),
  .cfg_load   (cfg_load),
  .in_vec     (in_vec),
  .out_vec    (out_vec),
  .cfg_shadow (cfg_shadow),
  .cfg_active (cfg_active)
);

// File: tb/test_pla_core.sv
module test_pla_core;

  localparam int N = 4;
  localparam int K = 6;
  localparam int M = 3;
  localparam int A_BITS = 2 * N * K;
  localparam int O_BITS = K * M;
  localparam int TOTAL  = A_BITS + O_BITS + M;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_shift, cfg_din, cfg_load;
  logic [N-1:0] in_vec;
  logic [M-1:0] out_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_core #(.N_IN(N), .N_TERM(K), .N_OUT(M)) i_pla_core (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
    .cfg_load(cfg_load), .in_vec(in_vec), .out_vec(out_vec)
  );

  // configuration index helpers, taken from the layout in R2
  function automatic int ai(int t, int i, int c);
    return t*2*N + 2*i + c;
  endfunction
  function automatic int oi(int o, int t);
    return A_BITS + o*K + t;
  endfunction
  function automatic int pi(int o);
    return A_BITS + O_BITS + o;
  endfunction

  function automatic logic [M-1:0] ref_out(input logic [TOTAL-1:0] c, input logic [N-1:0] x);
    logic [K-1:0] pt;
    logic [M-1:0] r;
    logic         any, all;
    for (int t = 0; t < K; t++) begin
      any = 1'b0;
      all = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (c[ai(t,i,0)]) begin any = 1'b1; if (!x[i]) all = 1'b0; end
        if (c[ai(t,i,1)]) begin any = 1'b1; if (x[i])  all = 1'b0; end
      end
      pt[t] = any & all;
    end
    for (int o = 0; o < M; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < K; t++) if (c[oi(o,t)] && pt[t]) r[o] = 1'b1;
      r[o] = r[o] ^ c[pi(o)];
    end
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input logic [M-1:0] act, input logic [M-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_vec actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic shift_cfg(input logic [TOTAL-1:0] c);
    for (int s = 0; s < TOTAL; s++) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_din   = c[s];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cfg_din   = 1'b0;
  endtask

  task automatic load_cfg(input logic [TOTAL-1:0] c);
    shift_cfg(c);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // R11: each vector is applied and sampled with no clock edge in between
  task automatic check_all(input logic [TOTAL-1:0] c, input string req);
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk);
      in_vec = v[N-1:0];
      #1;
      check(out_vec, ref_out(c, in_vec), req);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0; cfg_load = 1'b0; in_vec = '1;
    repeat (3) @(negedge clk);
    check(out_vec, '0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all('0, "R1 after reset");
  endtask

  task automatic t_empty_polarity();
    logic [TOTAL-1:0] c = '0;
    for (int o = 0; o < M; o++) c[pi(o)] = 1'b1;
    load_cfg(c);
    check_all(c, "R9 R10 R6 empty");
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk); in_vec = v[N-1:0]; #1;
      check(out_vec, '1, "R10 inverted empty");
    end
  endtask

  task automatic t_literals();
    logic [TOTAL-1:0] c = '0;
    c[ai(0,0,0)] = 1'b1; c[oi(0,0)] = 1'b1;           // out0 = in0
    c[ai(1,1,1)] = 1'b1; c[oi(1,1)] = 1'b1;           // out1 = ~in1
    c[ai(2,2,0)] = 1'b1; c[ai(2,3,1)] = 1'b1;         // term2 = in2 & ~in3
    c[oi(2,2)] = 1'b1; c[pi(2)] = 1'b1;               // out2 = ~(in2 & ~in3)
    load_cfg(c);
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk); in_vec = v[N-1:0]; #1;
      check(out_vec, {~(in_vec[2] & ~in_vec[3]), ~in_vec[1], in_vec[0]}, "R5 literal");
    end
  endtask

  task automatic t_contradiction();
    logic [TOTAL-1:0] c = '0;
    c[ai(3,1,0)] = 1'b1; c[ai(3,1,1)] = 1'b1;
    for (int o = 0; o < M; o++) c[oi(o,3)] = 1'b1;
    load_cfg(c);
    check_all(c, "R7 contradiction");
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk); in_vec = v[N-1:0]; #1;
      check(out_vec, '0, "R7 term stays 0");
    end
  endtask

  task automatic t_shared();
    logic [TOTAL-1:0] c = '0;
    c[ai(4,0,0)] = 1'b1; c[ai(4,1,0)] = 1'b1;         // term4 = in0 & in1
    c[ai(5,3,0)] = 1'b1;                              // term5 = in3
    for (int o = 0; o < M; o++) c[oi(o,4)] = 1'b1;
    c[oi(1,5)] = 1'b1;
    c[pi(2)] = 1'b1;
    load_cfg(c);
    for (int v = 0; v < (1 << N); v++) begin
      @(negedge clk); in_vec = v[N-1:0]; #1;
      check(out_vec, {~(in_vec[0] & in_vec[1]), (in_vec[0] & in_vec[1]) | in_vec[3],
                      in_vec[0] & in_vec[1]}, "R8 shared term");
    end
  endtask

  task automatic t_no_load_then_load();
    logic [TOTAL-1:0] ca = '0;
    logic [TOTAL-1:0] cb = '0;
    for (int o = 0; o < M; o++) cb[pi(o)] = 1'b1;
    load_cfg(ca);
    shift_cfg(cb);
    check_all(ca, "R4 shift without load");
    @(negedge clk);
    in_vec   = 4'h5;
    cfg_load = 1'b1;
    #1;
    check(out_vec, '0, "R3 before load edge");
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
    check(out_vec, '1, "R3 after load edge");
    check_all(cb, "R3 new function");
  endtask

  task automatic t_random();
    logic [TOTAL-1:0] c;
    for (int n = 0; n < 8; n++) begin
      c = '0;
      for (int b = 0; b < A_BITS; b++) c[b] = ($urandom % 5) == 0;
      for (int b = A_BITS; b < TOTAL; b++) c[b] = $urandom % 2;
      load_cfg(c);
      check_all(c, "R2 R8 R11 random");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_empty_polarity();
    t_literals();
    t_contradiction();
    t_shared();
    t_no_load_then_load();
    t_random();
    finish_run();
  end

endmodule